// File: doc/BRIEF.md
# Command Queue Pointer Register Block

This block is the register and interrupt front end of a host-facing DMA engine's command queue. Software programs a queue base and an end pointer, then posts work by writing the write pointer. The data mover behind it is not modelled. Completion is instant: the write-pointer write is copied into the read pointer in the same clock edge, both transfer-direction completion flags are raised in the status register, and the interrupt line rises if either flag is enabled in the control register.

A recognised magic value written to the read-pointer register arms a one-shot suppress flag. The next write-pointer write still moves both pointers, but it consumes the flag and reports no completion. The register window is addressed by 32-bit word index (byte offset divided by four). Writes take effect at the clock edge and reads are combinational. Every other in-window word is plain storage.

Top module: `cqp_regs`

## Requirements
- R1: After reset every register reads zero except status (word 15), which reads 0xF8000000. The interrupt output is low and the suppress flag is clear.
- R2: A write to any in-window word without special handling, including the queue base at word 5, stores all 32 bits and reads back unchanged.
- R3: A write to the end pointer (word 6) stores the data ANDed with parameter QPTR_MASK (default 0x00FFFFFF).
- R4: A write to the write pointer (word 7) stores data AND QPTR_MASK, and the same value appears in the read pointer (word 8) after the same edge.
- R5: A write to the read pointer leaves its stored value unchanged. A value other than parameter MAGIC (default 0xEE882266) does not arm suppression.
- R6: Writing MAGIC to the read pointer arms suppression. The next write-pointer write updates both pointers, clears the flag and sets no status bit. The following write-pointer write completes normally.
- R7: A completing write-pointer write sets status bits 16 and 17 and leaves the other status bits unchanged.
- R8: The interrupt goes high on the edge after a completing write when control bit 16 or 17 is set. It stays low when neither bit is set. It does not fall by itself.
- R9: Control (word 14) stores the data ANDed with parameter CTRL_WMASK (default 0x017003FF).
- R10: A status write with bit 16 or 17 set clears both bits, keeps the other bits and lowers the interrupt. A status write with neither bit set changes nothing.
- R11: An address whose index lies outside the NUM_REGS-word window is ignored on write and reads zero. It never aliases onto an in-window word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | ADDR_W | Word index of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Completion interrupt, level |

## Verification
The hardest situation to reach is the one-shot suppression. It needs a magic read-pointer write followed by two write-pointer writes. The bench must see that the first write moves both pointers without touching status, and that the second write completes again. The bench reaches it through a dedicated task sequence. Before that sequence it shows that a non-magic read-pointer write does not arm the flag. The interrupt path also needs a control mask that exposes the enable bits, so the bench instance overrides CTRL_WMASK to include bits 16 and 17. It then checks both an enabled and a disabled completion.

// File: rtl/cqp_pkg.sv
package cqp_pkg;
  // word indices inside the register window
  localparam int QBASE_IDX = 5;
  localparam int QEND_IDX  = 6;
  localparam int WRP_IDX   = 7;
  localparam int RDP_IDX   = 8;
  localparam int CTRL_IDX  = 14;
  localparam int STAT_IDX  = 15;

  localparam logic [31:0] COMP_BITS  = 32'h0003_0000;
  localparam logic [31:0] STATUS_RST = 32'hF800_0000;
endpackage

// File: rtl/cqp_decode.sv
module cqp_decode #(
  parameter int ADDR_W   = 10,
  parameter int NUM_REGS = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range,
  output logic              wr_hit,
  output logic              wrp_wr,
  output logic              rdp_wr,
  output logic              stat_clr
);
  import cqp_pkg::*;

  assign idx      = bus_addr[IDX_W-1:0];
  assign in_range = ~|bus_addr[ADDR_W-1:IDX_W];
  assign wr_hit   = bus_wr & in_range;
  assign wrp_wr   = wr_hit && (idx == IDX_W'(WRP_IDX));
  assign rdp_wr   = wr_hit && (idx == IDX_W'(RDP_IDX));
  assign stat_clr = wr_hit && (idx == IDX_W'(STAT_IDX)) && |(bus_wdata & COMP_BITS);
endmodule

// File: rtl/cqp_suppress.sv
module cqp_suppress #(
  parameter logic [31:0] MAGIC = 32'hEE88_2266
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrp_wr,
  input  logic        rdp_wr,
  input  logic [31:0] wdata,
  output logic        complete
);
  logic armed;

  assign complete = wrp_wr & ~armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        armed <= 1'b0;
    else if (rdp_wr && wdata == MAGIC) armed <= 1'b1;
    else if (wrp_wr)                   armed <= 1'b0;
  end

  // R6
  arm_on_magic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdp_wr && wdata == MAGIC) |=> armed);

  // R6
  one_shot_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrp_wr && armed) |=> !armed);
endmodule

// File: rtl/cqp_regfile.sv
module cqp_regfile #(
  parameter int          NUM_REGS   = 32,
  parameter logic [31:0] QPTR_MASK  = 32'h00FF_FFFF,
  parameter logic [31:0] CTRL_WMASK = 32'h0170_03FF,
  localparam int         IDX_W      = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [IDX_W-1:0] idx,
  input  logic             in_range,
  input  logic [31:0]      wdata,
  input  logic             complete,
  input  logic             stat_clr,
  output logic [31:0]      rdata,
  output logic [31:0]      ctrl_q
);
  import cqp_pkg::*;

  logic [31:0] words [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    logic [31:0] q;
    assign words[g] = q;

    if (g == RDP_IDX) begin : g_rdp
      // only the write-pointer mirror updates this word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (wr_hit && idx == IDX_W'(WRP_IDX)) q <= wdata & QPTR_MASK;
      end
    end else if (g == STAT_IDX) begin : g_stat
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= STATUS_RST;
        else if (complete) q <= q | COMP_BITS;
        else if (stat_clr) q <= q & ~COMP_BITS;
      end

      // R7
      status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> ((q & COMP_BITS) == COMP_BITS) && ((q & ~COMP_BITS) == $past(q & ~COMP_BITS)));
    end else begin : g_plain
      localparam logic [31:0] WMASK =
        (g == QEND_IDX || g == WRP_IDX) ? QPTR_MASK :
        (g == CTRL_IDX)                 ? CTRL_WMASK : 32'hFFFF_FFFF;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (wr_hit && idx == IDX_W'(g)) q <= wdata & WMASK;
      end
    end
  end

  assign rdata  = in_range ? words[idx] : '0;
  assign ctrl_q = words[CTRL_IDX];

  // R4
  rdp_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && idx == IDX_W'(WRP_IDX)) |=> words[RDP_IDX] == words[WRP_IDX]);
endmodule

// File: rtl/cqp_irq.sv
module cqp_irq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        complete,
  input  logic        stat_clr,
  input  logic [31:0] ctrl_q,
  output logic        irq
);
  import cqp_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 irq <= 1'b0;
    else if (complete && |(ctrl_q & COMP_BITS)) irq <= 1'b1;
    else if (stat_clr)                          irq <= 1'b0;
  end

  // R8
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(complete));

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !complete) |=> !irq);
endmodule

// File: rtl/cqp_regs.sv
module cqp_regs #(
  parameter int          ADDR_W     = 10,
  parameter int          NUM_REGS   = 32,
  parameter logic [31:0] MAGIC      = 32'hEE88_2266,
  parameter logic [31:0] QPTR_MASK  = 32'h00FF_FFFF,
  parameter logic [31:0] CTRL_WMASK = 32'h0170_03FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [IDX_W-1:0] idx;
  logic in_range, wr_hit, wrp_wr, rdp_wr, stat_clr, complete;
  logic [31:0] ctrl_q;

  cqp_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .idx(idx), .in_range(in_range), .wr_hit(wr_hit),
    .wrp_wr(wrp_wr), .rdp_wr(rdp_wr), .stat_clr(stat_clr)
  );

  cqp_suppress #(.MAGIC(MAGIC)) u_suppress (
    .clk(clk), .rst_n(rst_n), .wrp_wr(wrp_wr), .rdp_wr(rdp_wr),
    .wdata(bus_wdata), .complete(complete)
  );

  cqp_regfile #(.NUM_REGS(NUM_REGS), .QPTR_MASK(QPTR_MASK), .CTRL_WMASK(CTRL_WMASK)) u_regfile (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .idx(idx), .in_range(in_range),
    .wdata(bus_wdata), .complete(complete), .stat_clr(stat_clr),
    .rdata(bus_rdata), .ctrl_q(ctrl_q)
  );

  cqp_irq u_irq (
    .clk(clk), .rst_n(rst_n), .complete(complete), .stat_clr(stat_clr),
    .ctrl_q(ctrl_q), .irq(irq)
  );
endmodule

// File: tb/cqp_regs_bench.sv
module cqp_regs_bench;
  localparam logic [31:0] MAGIC  = 32'hEE88_2266;
  localparam logic [31:0] QMASK  = 32'h00FF_FFFF;
  localparam logic [31:0] CMASK  = 32'h0173_03FF;
  localparam logic [31:0] ST_RST = 32'hF800_0000;
  localparam logic [31:0] ST_CMP = 32'hF803_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cqp_regs #(.CTRL_WMASK(CMASK)) u_cqp_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 10'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 10'(a);
    #1 d = bus_rdata;
  endtask

  task automatic expect_rd(string req, int a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    expect_rd("R1 qbase", 5, 0);
    expect_rd("R1 end", 6, 0);
    expect_rd("R1 wrp", 7, 0);
    expect_rd("R1 rdp", 8, 0);
    expect_rd("R1 ctrl", 14, 0);
    expect_rd("R1 status", 15, ST_RST);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_storage;
    wr(5, 32'hA5A5_1234);  expect_rd("R2 qbase", 5, 32'hA5A5_1234);
    wr(0, 32'hFFFF_FFFF);  expect_rd("R2 word0", 0, 32'hFFFF_FFFF);
    wr(17, 32'h1234_5678); expect_rd("R2 word17", 17, 32'h1234_5678);
  endtask

  task automatic t_endp;
    wr(6, 32'hFFFF_FFFF); expect_rd("R3 end masked", 6, QMASK);
  endtask

  task automatic t_wrp;
    wr(7, 32'hAB12_3456);
    expect_rd("R4 wrp masked", 7, 32'h0012_3456);
    expect_rd("R4 rdp mirror", 8, 32'h0012_3456);
    expect_rd("R7 status set", 15, ST_CMP);
    check("R8 irq low with ctrl zero", {31'b0, irq}, 0);
    wr(15, 32'h0001_0000);
    expect_rd("R10 status cleared", 15, ST_RST);
  endtask

  task automatic t_rdp_plain;
    wr(8, 32'h1111_1111);
    expect_rd("R5 rdp kept", 8, 32'h0012_3456);
    wr(7, 32'h10);
    expect_rd("R5 not armed, completes", 15, ST_CMP);
    wr(15, 32'h0002_0000);
  endtask

  task automatic t_suppress;
    wr(8, MAGIC);
    expect_rd("R6 rdp kept on magic", 8, 32'h10);
    wr(7, 32'h20);
    expect_rd("R6 suppressed rdp moves", 8, 32'h20);
    expect_rd("R6 suppressed no status", 15, ST_RST);
    wr(7, 32'h30);
    expect_rd("R6 next completes", 15, ST_CMP);
    wr(15, 32'h0003_0000);
  endtask

  task automatic t_irq;
    wr(14, 32'hFFFF_FFFF);
    expect_rd("R9 ctrl masked", 14, CMASK);
    wr(7, 32'h40);
    check("R8 irq raised", {31'b0, irq}, 1);
    wr(15, 32'h8000_0000);
    expect_rd("R10 no-comp write no effect", 15, ST_CMP);
    check("R10 irq held", {31'b0, irq}, 1);
    wr(15, 32'h0002_0000);
    expect_rd("R10 clear keeps upper", 15, ST_RST);
    check("R10 irq lowered", {31'b0, irq}, 0);
    wr(14, 32'h1);
    wr(7, 32'h50);
    check("R8 irq stays low unenabled", {31'b0, irq}, 0);
    expect_rd("R7 status set again", 15, ST_CMP);
    wr(15, 32'h0001_0000);
  endtask

  task automatic t_oor;
    wr(32, 32'hDEAD_BEEF);
    expect_rd("R11 oor reads zero", 32, 0);
    expect_rd("R11 no alias word0", 0, 32'hFFFF_FFFF);
    wr(39, 32'h77);
    expect_rd("R11 no alias wrp", 7, 32'h50);
    expect_rd("R11 no completion", 15, ST_RST);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_storage();
    t_endp();
    t_wrp();
    t_rdp_plain();
    t_suppress();
    t_irq();
    t_oor();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule